// File: doc/BRIEF.md
# Pipeline Interlock Unit

This unit decides, one cycle at a time, whether the micro-op now sitting in the decode stage of an in-order pipeline may move on to register read. The front end of the pipeline runs fetch, micro-op conversion, decode and register read. After that, work splits into three execution paths of unequal length. An integer add uses one integer ALU stage. A load or store uses the integer ALU for address generation and then three data-memory stages. A floating-point add uses four FP stages. Every path ends in a register write stage. The register file is written in the first half of a cycle and read in the second half, and it has enough write ports that two results can never conflict.

The unit keeps a scoreboard with one countdown per architectural register. When a result-producing micro-op leaves decode, the unit loads that register's countdown with the number of cycles that must pass before a reader can obtain the value. A static mode input chooses between two ways of obtaining it: only from the register file, or through full forwarding from the stage that produces the result. A store's two sources have different deadlines. Its address must be ready when it enters the integer ALU, but its data is only needed when it enters the first data-memory stage. While stall is high, decode and the stages before it hold their contents, and a bubble goes into register read in the next cycle. Countdowns keep running during a stall.

Top module: `pipe_interlock`

## Requirements
- R1: After reset, every register is free. stall and bubble are low, and no operand stalls until a producer has been accepted.
- R2: stall is never high while dec_valid is low. An idle decode slot changes no scoreboard state.
- R3: bubble is high in the cycle after each cycle in which stall was high, and it is low in every other cycle.
- R4: With bypass_en low, a consumer leaves decode no earlier than the cycle before its producer's register-write cycle. A dependent micro-op placed directly after its producer therefore stalls 1 cycle behind an integer add, and 4 cycles behind a load or an FP add. This holds for any source, including store address and store data.
- R5: With bypass_en high, a source needed at execute entry waits until the producing stage has finished. Integer add to dependent integer add stalls 0 cycles. FP add to dependent FP add stalls 3 cycles. Load to store address stalls 3 cycles.
- R6: With bypass_en high, the data source of a store has one more cycle of slack than its address source, because it is needed at entry to the first data-memory stage. Load to store data and FP add to store data each stall 2 cycles.
- R7: A micro-op that writes a register waits while an older in-flight write to that same register would reach register write in the same cycle as its own write or later.
- R8: Only micro-ops that leave decode and write a register reserve a scoreboard entry. A store reserves none, and a stalled micro-op reserves none. Countdowns advance every cycle, so no single micro-op stalls for more than 4 consecutive cycles.
- R9: dec_class encodes 0 = integer add (reads src_a and src_b, writes dst), 1 = load (reads src_a as its address, writes dst), 2 = store (src_a is the address, src_b is the data), 3 = FP add (reads src_a and src_b, writes dst). A field that the class does not use never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | 1 = full forwarding, 0 = register file only; changed only during reset |
| dec_valid | input | 1 | The decode slot holds a micro-op |
| dec_class | input | 2 | Micro-op class (encoding in R9) |
| dec_src_a | input | 5 | First source register |
| dec_src_b | input | 5 | Second source register |
| dec_dst | input | 5 | Destination register |
| stall | output | 1 | Hold decode and earlier stages this cycle |
| bubble | output | 1 | Register read holds an inserted bubble this cycle |

## Verification
Some properties are checked on every cycle. Stall is never raised for an empty slot. The bubble follows each stall cycle by exactly one cycle. A stall run never lasts more than four cycles. An integer add right after its integer producer goes through with forwarding and waits without it, and an FP add right after its FP producer always waits. The exact stall counts need directed scenarios in the bench: the five dependent pairs in both modes, the extra slack given to store data, write-after-write ordering, and unused fields being ignored. A behavioural model in the bench, built on absolute write and forward cycles, checks these counts and also checks long random streams.

// File: rtl/pil_pkg.sv
package pil_pkg;

  typedef enum logic [1:0] {
    UOP_INT   = 2'd0,
    UOP_LOAD  = 2'd1,
    UOP_STORE = 2'd2,
    UOP_FP    = 2'd3
  } uop_class_e;

  function automatic logic reads_b(uop_class_e c);
    return c != UOP_LOAD;
  endfunction

  function automatic logic writes_dst(uop_class_e c);
    return c != UOP_STORE;
  endfunction

endpackage

// File: rtl/pil_latency.sv
module pil_latency
  import pil_pkg::*;
#(
  parameter int INT_EX  = 1,
  parameter int MEM_STG = 3,
  parameter int FP_STG  = 4,
  parameter int CW      = 3
) (
  input  logic            bypass_en,
  input  uop_class_e      cls,
  output logic [CW-1:0]   ld_val,
  output logic [CW-1:0]   data_slack
);
  // Register-write stage offset measured from the cycle the producer leaves decode
  localparam int INT_RW = 2 + INT_EX;
  localparam int MEM_RW = 2 + INT_EX + MEM_STG;
  localparam int FP_RW  = 2 + FP_STG;

  logic [CW-1:0] rw_sel;

  always_comb begin
    unique case (cls)
      UOP_INT:  rw_sel = CW'(INT_RW);
      UOP_FP:   rw_sel = CW'(FP_RW);
      default:  rw_sel = CW'(MEM_RW);
    endcase
  end

  // Without forwarding a reader waits for register write (RW-2 remaining).
  // With forwarding the value is usable one stage earlier (RW-3 remaining).
  assign ld_val     = bypass_en ? (rw_sel - CW'(3)) : (rw_sel - CW'(2));
  assign data_slack = bypass_en ? CW'(INT_EX) : '0;

endmodule

// File: rtl/pil_scoreboard.sv
module pil_scoreboard #(
  parameter int NREG = 32,
  parameter int CW   = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_idx,
  input  logic [CW-1:0] ld_val,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  input  logic [AW-1:0] rd_d,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic [CW-1:0] cnt_d
);
  logic [CW-1:0] cnt [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        cnt[i] <= '0;
      else if (ld_en && ld_idx == AW'(i))
        cnt[i] <= ld_val;
      else if (cnt[i] != '0)
        cnt[i] <= cnt[i] - CW'(1);
    end
  end

  assign cnt_a = cnt[rd_a];
  assign cnt_b = cnt[rd_b];
  assign cnt_d = cnt[rd_d];

endmodule

// File: rtl/pil_hazard.sv
module pil_hazard
  import pil_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          valid,
  input  uop_class_e    cls,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic [CW-1:0] cnt_d,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] data_slack,
  output logic          stall
);
  logic haz_a, haz_b, haz_w;

  always_comb begin
    haz_a = cnt_a != '0;
    if (!reads_b(cls))
      haz_b = 1'b0;
    else if (cls == UOP_STORE)
      haz_b = cnt_b > data_slack;
    else
      haz_b = cnt_b != '0;
    // An older write landing at or after ours would leave a stale value
    haz_w = writes_dst(cls) && (cnt_d > ld_val);
    stall = valid && (haz_a || haz_b || haz_w);
  end

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pil_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int INT_EX  = 1,
  parameter int MEM_STG = 3,
  parameter int FP_STG  = 4,
  localparam int AW     = $clog2(NREG),
  localparam int MAX_RW = 2 + ((INT_EX + MEM_STG > FP_STG) ? (INT_EX + MEM_STG) : FP_STG),
  localparam int CW     = $clog2(MAX_RW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bypass_en,
  input  logic          dec_valid,
  input  logic [1:0]    dec_class,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic [AW-1:0] dec_dst,
  output logic          stall,
  output logic          bubble
);
  uop_class_e    cls;
  logic [CW-1:0] ld_val, data_slack;
  logic [CW-1:0] cnt_a, cnt_b, cnt_d;
  logic          reserve;
  logic          bubble_q;

  assign cls = uop_class_e'(dec_class);

  pil_latency #(.INT_EX(INT_EX), .MEM_STG(MEM_STG), .FP_STG(FP_STG), .CW(CW)) u_lat (
    .bypass_en (bypass_en),
    .cls       (cls),
    .ld_val    (ld_val),
    .data_slack(data_slack)
  );

  assign reserve = dec_valid && !stall && writes_dst(cls);

  pil_scoreboard #(.NREG(NREG), .CW(CW)) u_sb (
    .clk   (clk),
    .rst   (rst),
    .ld_en (reserve),
    .ld_idx(dec_dst),
    .ld_val(ld_val),
    .rd_a  (dec_src_a),
    .rd_b  (dec_src_b),
    .rd_d  (dec_dst),
    .cnt_a (cnt_a),
    .cnt_b (cnt_b),
    .cnt_d (cnt_d)
  );

  pil_hazard #(.CW(CW)) u_haz (
    .valid     (dec_valid),
    .cls       (cls),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .cnt_d     (cnt_d),
    .ld_val    (ld_val),
    .data_slack(data_slack),
    .stall     (stall)
  );

  always_ff @(posedge clk) begin
    if (rst) bubble_q <= 1'b0;
    else     bubble_q <= stall;
  end

  assign bubble = bubble_q;

endmodule

// File: rtl/pil_checker.sv
module pil_checker #(
  parameter int AW    = 5,
  parameter int LIMIT = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bypass_en,
  input logic          dec_valid,
  input logic [1:0]    dec_class,
  input logic [AW-1:0] dec_src_a,
  input logic [AW-1:0] dec_src_b,
  input logic [AW-1:0] dec_dst,
  input logic          stall,
  input logic          bubble
);
  logic armed;
  int   run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      run_len <= 0;
    end else begin
      armed   <= 1'b1;
      run_len <= stall ? run_len + 1 : 0;
    end
  end

  // R2
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !stall);

  // R3
  bubble_follows_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> bubble);

  // R3
  no_stray_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> !bubble);

  // R8
  stall_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_len <= LIMIT);

  // R5
  int_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && bypass_en && dec_valid && dec_class == 2'd0 &&
     $past(dec_valid && !stall && dec_class == 2'd0) &&
     dec_src_a == $past(dec_dst) && dec_src_b == $past(dec_dst) &&
     dec_dst == $past(dec_dst)) |-> !stall);

  // R4
  int_nofwd_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !bypass_en && dec_valid && dec_class == 2'd0 &&
     $past(dec_valid && !stall && dec_class == 2'd0) &&
     dec_src_a == $past(dec_dst)) |-> stall);

  // R5
  fp_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && dec_valid && dec_class == 2'd3 &&
     $past(dec_valid && !stall && dec_class == 2'd3) &&
     dec_src_a == $past(dec_dst)) |-> stall);

endmodule

bind pipe_interlock pil_checker #(.AW(AW), .LIMIT(MAX_RW - 2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bypass_en(bypass_en),
  .dec_valid(dec_valid),
  .dec_class(dec_class),
  .dec_src_a(dec_src_a),
  .dec_src_b(dec_src_b),
  .dec_dst  (dec_dst),
  .stall    (stall),
  .bubble   (bubble)
);

// File: tb/pipe_interlock_tb.sv
`timescale 1ns/1ps
module pipe_interlock_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bypass_en = 1'b0;
  logic       dec_valid = 1'b0;
  logic [1:0] dec_class = 2'd0;
  logic [4:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic       stall, bubble;

  int checks = 0, fails = 0, cyc = 0;
  int rw_abs [32];
  int p_abs  [32];
  bit prev_exp = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pipe_interlock u_dut (
    .clk(clk), .rst(rst), .bypass_en(bypass_en), .dec_valid(dec_valid),
    .dec_class(dec_class), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_dst(dec_dst), .stall(stall), .bubble(bubble)
  );

  // Model offsets from the decode-exit cycle: register write and last producing stage
  function automatic int rw_off(logic [1:0] c);
    return (c == 2'd0) ? 3 : 6;
  endfunction
  function automatic int p_off(logic [1:0] c);
    return (c == 2'd0) ? 2 : 5;
  endfunction
  function automatic bit src_ok(int r, int need);
    if (bypass_en) return cyc + need >= p_abs[r] + 1;
    return cyc + 1 >= rw_abs[r];
  endfunction

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Sample between edges, compare, advance model; drive next inputs after the edge
  task automatic tick(output bit acc);
    bit exp;
    @(negedge clk);
    exp = 1'b0;
    if (!rst && dec_valid) begin
      if (!src_ok(dec_src_a, 2)) exp = 1'b1;
      if (dec_class != 2'd1 && !src_ok(dec_src_b, (dec_class == 2'd2) ? 3 : 2)) exp = 1'b1;
      if (dec_class != 2'd2 && !(cyc + rw_off(dec_class) > rw_abs[dec_dst])) exp = 1'b1;
    end
    if (rst) begin
      expect_eq("R1 stall in reset", int'(stall), 0);
      expect_eq("R1 bubble in reset", int'(bubble), 0);
    end else begin
      expect_eq(!dec_valid ? "R2 idle stall" : (bypass_en ? "R5 stall" : "R4 stall"),
                int'(stall), int'(exp));
      expect_eq("R3 bubble", int'(bubble), int'(prev_exp));
    end
    prev_exp = exp && !rst;
    acc = !rst && dec_valid && !exp;
    if (acc && dec_class != 2'd2) begin
      rw_abs[dec_dst] = cyc + rw_off(dec_class);
      p_abs[dec_dst]  = cyc + p_off(dec_class);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit mode);
    bit acc;
    rst = 1'b1;
    dec_valid = 1'b0;
    bypass_en = mode;
    for (int i = 0; i < 32; i++) begin
      rw_abs[i] = -100;
      p_abs[i]  = -100;
    end
    repeat (3) tick(acc);
    rst = 1'b0;
    prev_exp = 1'b0;
  endtask

  task automatic idle(int n);
    bit acc;
    dec_valid = 1'b0;
    repeat (n) tick(acc);
  endtask

  task automatic send(logic [1:0] c, logic [4:0] a, logic [4:0] b, logic [4:0] d,
                      output int stalls);
    bit acc;
    dec_valid = 1'b1; dec_class = c; dec_src_a = a; dec_src_b = b; dec_dst = d;
    stalls = 0;
    do begin
      tick(acc);
      if (!acc) stalls++;
    end while (!acc && stalls < 20);
    dec_valid = 1'b0;
  endtask

  // Producer into r5, then the consumer straight after; return consumer stalls
  task automatic pair(logic [1:0] pc, logic [1:0] cc, bit on_b, string tag, int exp);
    int s;
    idle(8);
    send(pc, 5'd1, 5'd2, 5'd5, s);
    send(cc, on_b ? 5'd3 : 5'd5, on_b ? 5'd5 : 5'd4, 5'd9, s);
    expect_eq(tag, s, exp);
  endtask

  initial begin
    int s;
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      // R1: nothing reserved after reset
      send(2'd3, 5'd5, 5'd6, 5'd7, s);
      expect_eq("R1 first op free", s, 0);
      if (m == 0) begin
        pair(2'd0, 2'd0, 1'b0, "R4 int->int", 1);
        pair(2'd3, 2'd3, 1'b1, "R4 fp->fp", 4);
        pair(2'd1, 2'd2, 1'b0, "R4 load->store addr", 4);
        pair(2'd1, 2'd2, 1'b1, "R4 load->store data", 4);
        pair(2'd3, 2'd2, 1'b1, "R4 fp->store data", 4);
      end else begin
        pair(2'd0, 2'd0, 1'b0, "R5 int->int", 0);
        pair(2'd3, 2'd3, 1'b1, "R5 fp->fp", 3);
        pair(2'd1, 2'd2, 1'b0, "R5 load->store addr", 3);
        pair(2'd1, 2'd2, 1'b1, "R6 load->store data", 2);
        pair(2'd3, 2'd2, 1'b1, "R6 fp->store data", 2);
      end
      // R7: int writing the same register right after an FP add
      idle(8);
      send(2'd3, 5'd1, 5'd2, 5'd10, s);
      send(2'd0, 5'd3, 5'd4, 5'd10, s);
      expect_eq("R7 waw fp then int", s, m ? 3 : 3);
      // R8: a store reserves nothing under its dst field
      idle(8);
      send(2'd2, 5'd1, 5'd2, 5'd11, s);
      send(2'd0, 5'd11, 5'd11, 5'd12, s);
      expect_eq("R8 store no reserve", s, 0);
      // R9: load ignores src_b even when that register is busy
      idle(8);
      send(2'd3, 5'd1, 5'd2, 5'd13, s);
      send(2'd1, 5'd14, 5'd13, 5'd15, s);
      expect_eq("R9 load ignores src_b", s, 0);
      // Random stream over a few registers, model compared every cycle
      idle(8);
      for (int k = 0; k < 400; k++) begin
        if ($urandom_range(0, 3) == 0) idle(1);
        send(2'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
             5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), s);
      end
      idle(8);
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule